// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbitration

This block is a synchronous 2048 x 8 memory with two identical ports, left and right. Each port has an address, an active-low select, an active-low read enable, a direction bit, write data, and read data with a valid flag. The valid flag takes the place of a three-state output. Accesses to different locations run side by side, two writes included, and neither port waits.

When both ports are selected and point at the same location, the arbiter picks one port to proceed. A port that was already present wins. A port counts as present when, in the previous cycle, it was selected at the same address it holds now. The other port gets an active-low busy flag, so its write is dropped and its read is reported invalid. If both ports arrive in the same cycle, the left port wins. The winner keeps the location until the match ends. Busy is registered, but the losing write is already suppressed in the first cycle of the match.

Top module: `dpram_arb`

## Requirements
- R1: While reset is high and in the cycle after it, both busy outputs are high (idle) and both read-valid flags are low.
- R2: A selected port with direction bit 0 writes its data at the clock edge. A selected port with direction bit 1 and read enable low shows the stored byte on its read data, with valid high, one cycle later. When valid is low, the read data is zero.
- R3: Both ports selected at equal addresses makes exactly one busy output go low on the next cycle. Busy returns high on the cycle after the match ends.
- R4: When both ports reach the same address in the same cycle, the right port's busy goes low and the left port proceeds.
- R5: A port becomes the later arrival in either of two ways: it turns its select on while the addresses already match, or it moves its address onto the other port's address while both are selected. The later arrival gets busy.
- R6: While the match persists, busy stays on the same port.
- R7: The losing port's write does not reach memory, including in the first cycle of the match.
- R8: A read by the losing port yields valid low for that cycle.
- R9: A deselected port writes nothing and reports valid low. A selected read with read enable high also reports valid low.
- R10: Accesses to different addresses, two writes included, leave both busy outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_addr | input | 11 | Left address |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_rd | input | 1 | Left direction: 1 read, 0 write |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy, active low |
| r_addr | input | 11 | Right address |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_rd | input | 1 | Right direction: 1 read, 0 write |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy, active low |

## Verification
The bench builds the block with its default parameters: 11 address bits and 8 data bits. Random traffic is confined to sixteen locations, eight at the bottom of the address space and eight at the top. This keeps address collisions frequent, so ties, late arrivals, held ownership and releases recur many times. It also exercises the lowest and highest addresses.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpb_port_ctl.sv
module dpb_port_ctl (
  input  logic cs_n,
  input  logic oe_n,
  input  logic rd,
  input  logic lose,
  output logic en,
  output logic we,
  output logic re
);
  assign en = !cs_n;
  assign we = !cs_n && !rd && !lose;
  assign re = !cs_n && rd && !oe_n && !lose;
endmodule

// File: rtl/dpb_arbiter.sv
module dpb_arbiter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_lose,
  output logic              r_lose,
  output logic              l_busy_n,
  output logic              r_busy_n
);
  import dpb_pkg::*;

  owner_e            own_q, own_d;
  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              match, l_stay, r_stay;

  assign match  = l_en && r_en && (l_addr == r_addr);
  assign l_stay = l_en_q && (l_addr_q == l_addr);
  assign r_stay = r_en_q && (r_addr_q == r_addr);

  always_comb begin
    own_d = OWN_NONE;
    if (match) begin
      if (own_q != OWN_NONE)      own_d = own_q;
      else if (r_stay && !l_stay) own_d = OWN_RIGHT;
      else                        own_d = OWN_LEFT;
    end
  end

  assign l_lose = (own_d == OWN_RIGHT);
  assign r_lose = (own_d == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= OWN_NONE;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      own_q    <= own_d;
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_busy_n <= !l_lose;
      r_busy_n <= !r_lose;
    end
  end
endmodule

// File: rtl/dpb_ram.sv
module dpb_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Arbitration guarantees the two write addresses never coincide.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata  <= '0;
      b_rdata  <= '0;
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_re;
      b_rvalid <= b_re;
      a_rdata  <= a_re ? mem[a_addr] : '0;
      b_rdata  <= b_re ? mem[b_addr] : '0;
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_cs_n,
  input  logic              l_oe_n,
  input  logic              l_rd,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_cs_n,
  input  logic              r_oe_n,
  input  logic              r_rd,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_busy_n
);
  logic l_en, r_en, l_we, r_we, l_re, r_re, l_lose, r_lose;

  dpb_port_ctl u_lctl (
    .cs_n(l_cs_n), .oe_n(l_oe_n), .rd(l_rd), .lose(l_lose),
    .en(l_en), .we(l_we), .re(l_re)
  );

  dpb_port_ctl u_rctl (
    .cs_n(r_cs_n), .oe_n(r_oe_n), .rd(r_rd), .lose(r_lose),
    .en(r_en), .we(r_we), .re(r_re)
  );

  dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst),
    .l_en(l_en), .r_en(r_en), .l_addr(l_addr), .r_addr(r_addr),
    .l_lose(l_lose), .r_lose(r_lose),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n)
  );

  dpb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .a_we(l_we), .a_re(l_re), .a_addr(l_addr), .a_wdata(l_wdata),
    .a_rdata(l_rdata), .a_rvalid(l_rvalid),
    .b_we(r_we), .b_re(r_re), .b_addr(r_addr), .b_wdata(r_wdata),
    .b_rdata(r_rdata), .b_rvalid(r_rvalid)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_cs_n,
  input logic              r_cs_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_rvalid,
  input logic              r_rvalid,
  input logic              l_we,
  input logic              r_we
);
  logic same;
  assign same = !l_cs_n && !r_cs_n && (l_addr == r_addr);

  AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n)); // R3

  AST_MATCH_GIVES_BUSY: assert property (@(posedge clk) disable iff (rst)
    $past(same && !rst) |-> (!l_busy_n || !r_busy_n)); // R3

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n || !r_busy_n) |-> $past(same)); // R10

  AST_HOLD_RIGHT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (same && !r_busy_n) |=> !r_busy_n); // R6

  AST_HOLD_LEFT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (same && !l_busy_n) |=> !l_busy_n); // R6

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(l_we && r_we && l_addr == r_addr)); // R7

  AST_DESEL_LEFT_QUIET: assert property (@(posedge clk) disable iff (rst)
    l_cs_n |=> !l_rvalid); // R9

  AST_DESEL_RIGHT_QUIET: assert property (@(posedge clk) disable iff (rst)
    r_cs_n |=> !r_rvalid); // R9
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .l_addr(l_addr), .r_addr(r_addr),
  .l_cs_n(l_cs_n), .r_cs_n(r_cs_n), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_rvalid(l_rvalid), .r_rvalid(r_rvalid), .l_we(l_we), .r_we(r_we)
);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_cs_n = 1'b1, r_cs_n = 1'b1, l_oe_n = 1'b1, r_oe_n = 1'b1;
  logic l_rd = 1'b1, r_rd = 1'b1;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_n, r_busy_n;

  always #10 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_rd(l_rd),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
    .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_rd(r_rd),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_n(r_busy_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] m_mem [2048];
  int            m_own = 0;          // 0 none, 1 left owns, 2 right owns
  bit            m_len_q = 0, m_ren_q = 0;
  logic [AW-1:0] m_la_q = '0, m_ra_q = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int pick_owner(bit match, bit lstay, bit rstay, int own);
    if (!match) return 0;
    if (own != 0) return own;
    if (rstay && !lstay) return 2;
    return 1;
  endfunction

  // One cycle: inputs already driven; model, clock, compare at negedge.
  task automatic step();
    bit match, lstay, rstay, lwe, rwe, lre, rre;
    int nown;
    logic [DW-1:0] elrd, errd;
    match = !l_cs_n && !r_cs_n && (l_addr == r_addr);
    lstay = m_len_q && (m_la_q == l_addr);
    rstay = m_ren_q && (m_ra_q == r_addr);
    nown  = pick_owner(match, lstay, rstay, m_own);
    lwe = !l_cs_n && !l_rd && nown != 2;
    rwe = !r_cs_n && !r_rd && nown != 1;
    lre = !l_cs_n && l_rd && !l_oe_n && nown != 2;
    rre = !r_cs_n && r_rd && !r_oe_n && nown != 1;
    elrd = lre ? m_mem[l_addr] : '0;
    errd = rre ? m_mem[r_addr] : '0;
    if (lwe) m_mem[l_addr] = l_wdata;
    if (rwe) m_mem[r_addr] = r_wdata;
    m_own = nown;
    m_len_q = !l_cs_n; m_ren_q = !r_cs_n;
    m_la_q = l_addr;  m_ra_q = r_addr;
    @(posedge clk);
    @(negedge clk);
    chk(l_busy_n == (nown != 2), match ? "R3" : "R10", "l_busy_n", l_busy_n, nown != 2);
    chk(r_busy_n == (nown != 1), match ? "R3" : "R10", "r_busy_n", r_busy_n, nown != 1);
    chk(l_rvalid == lre, (nown == 2) ? "R8" : "R9", "l_rvalid", l_rvalid, lre);
    chk(r_rvalid == rre, (nown == 1) ? "R8" : "R9", "r_rvalid", r_rvalid, rre);
    chk(l_rdata === elrd, "R2", "l_rdata", l_rdata, elrd);
    chk(r_rdata === errd, "R2", "r_rdata", r_rdata, errd);
  endtask

  task automatic drive_l(input bit cs, input bit rd, input bit oe,
                         input int a, input int d);
    l_cs_n = !cs; l_rd = rd; l_oe_n = !oe; l_addr = a[AW-1:0]; l_wdata = d[DW-1:0];
  endtask

  task automatic drive_r(input bit cs, input bit rd, input bit oe,
                         input int a, input int d);
    r_cs_n = !cs; r_rd = rd; r_oe_n = !oe; r_addr = a[AW-1:0]; r_wdata = d[DW-1:0];
  endtask

  function automatic int win_addr(input int k);
    return (k < 8) ? k : 2032 + k;
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk(l_busy_n && r_busy_n, "R1", "busy during reset", {l_busy_n, r_busy_n}, 3);
    chk(!l_rvalid && !r_rvalid, "R1", "valid during reset", {l_rvalid, r_rvalid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(l_busy_n && r_busy_n && !l_rvalid && !r_rvalid, "R1", "after reset",
        {l_busy_n, r_busy_n, l_rvalid, r_rvalid}, 4'b1100);

    // preload window with parallel writes at different addresses
    for (int k = 0; k < 8; k++) begin
      drive_l(1, 0, 0, win_addr(k), 8'h10 + k);
      drive_r(1, 0, 0, win_addr(k + 8), 8'hA0 + k);
      step();
      chk(l_busy_n && r_busy_n, "R10", "parallel writes busy", {l_busy_n, r_busy_n}, 3);
    end

    // read back (R2)
    drive_l(1, 1, 1, 3, 0); drive_r(1, 1, 1, 2047, 0);
    step();
    chk(l_rvalid && l_rdata == 8'h13, "R2", "left readback", l_rdata, 8'h13);
    chk(r_rvalid && r_rdata == 8'hA7, "R2", "right readback", r_rdata, 8'hA7);
    drive_l(0, 1, 0, 0, 0); drive_r(0, 1, 0, 0, 0); step();

    // simultaneous arrival, both writing address 4 (R4, R7)
    drive_l(1, 0, 0, 4, 8'h55); drive_r(1, 0, 0, 4, 8'hEE);
    step();
    chk(!r_busy_n && l_busy_n, "R4", "tie goes to left", {l_busy_n, r_busy_n}, 2'b10);
    drive_l(0, 1, 0, 0, 0); drive_r(0, 1, 0, 0, 0); step();
    drive_l(1, 1, 1, 4, 0); step();
    chk(l_rdata == 8'h55, "R7", "right write blocked on tie", l_rdata, 8'h55);

    // enable-triggered: left present on 3, right enables writing 3 (R5, R7)
    drive_l(1, 1, 1, 3, 0); drive_r(0, 1, 0, 3, 0); step();
    drive_r(1, 0, 0, 3, 8'hCC); step();
    chk(!r_busy_n && l_busy_n, "R5", "late select gets busy", {l_busy_n, r_busy_n}, 2'b10);
    chk(l_rvalid && l_rdata == 8'h13, "R7", "first-cycle write blocked", l_rdata, 8'h13);
    drive_l(0, 1, 0, 0, 0); drive_r(0, 1, 0, 0, 0); step();
    chk(l_busy_n && r_busy_n, "R3", "release after match", {l_busy_n, r_busy_n}, 3);

    // address-triggered: right on 5, left moves onto 5 (R5, R6, R8)
    drive_l(1, 1, 1, 6, 0); drive_r(1, 1, 1, 5, 0); step();
    drive_l(1, 1, 1, 5, 0); step();
    chk(!l_busy_n && r_busy_n, "R5", "address move gets busy", {l_busy_n, r_busy_n}, 2'b01);
    chk(!l_rvalid, "R8", "loser read invalid", l_rvalid, 0);
    for (int k = 0; k < 4; k++) begin
      drive_l(1, 0, 0, 5, 8'h99); step();
      chk(!l_busy_n && r_busy_n, "R6", "owner held", {l_busy_n, r_busy_n}, 2'b01);
    end
    drive_l(1, 1, 1, 6, 0); step();
    chk(l_busy_n && r_busy_n, "R3", "release on address move", {l_busy_n, r_busy_n}, 3);
    drive_l(1, 1, 1, 5, 0); drive_r(0, 1, 1, 0, 0); step();
    chk(l_rdata == 8'h15, "R7", "held loser writes dropped", l_rdata, 8'h15);

    // deselected write and disabled read (R9)
    drive_l(0, 0, 0, 7, 8'h77); drive_r(1, 1, 0, 7, 0); step();
    chk(!r_rvalid && r_rdata == 0, "R9", "read enable off", r_rvalid, 0);
    drive_l(1, 1, 1, 7, 0); drive_r(0, 1, 0, 0, 0); step();
    chk(l_rdata == 8'h17, "R9", "deselected write ignored", l_rdata, 8'h17);

    // random traffic over the window
    for (int n = 0; n < 4000; n++) begin
      drive_l(($urandom % 4) != 0, $urandom % 2, ($urandom % 5) != 0,
              win_addr($urandom % 16), $urandom % 256);
      drive_r(($urandom % 4) != 0, $urandom % 2, ($urandom % 5) != 0,
              win_addr($urandom % 16), $urandom % 256);
      step();
    end

    done = 1'b1;
    finish_run();
  end
endmodule